// File: doc/BRIEF.md
# Golden Configuration Sequencer

This block runs once after a backup-image boot. It loads each slave management device in turn from an external serial flash. For each slave it fetches that slave's stored configuration image and writes it into the slave's shadow registers over a shared I2C bus. It then lets the slave confirm the write with a CRC comparison before the slave is told to load the new settings. Slave images sit in equal slots at a fixed stride above a base address. Each image carries a marker byte, the slave's bus address with a policy bit, the payload, the CRC and a trailer.

A slave marked optional whose presence line is low is passed over. Any slave that does not answer its identity query, or answers with the wrong identity, is skipped if it is optional. A mandatory slave in the same situation stops the run. A CRC mismatch makes the sequencer program that slave again, up to a parameterised number of repeats. Any fatal condition parks the sequencer with busy held high, which keeps every slave in its safe state until the next power-on reset. Logic downstream waits on busy, which falls only after every slave has been handled.

Top module: `gcfg_seq_top`

## Requirements
- R1: After reset, busy and fail are 0. A start pulse sampled on a clock edge makes busy 1 from that edge on. Busy returns to 0 with fail 0 only after every slave slot has been handled without a fatal condition. Start is ignored once the run has begun.
- R2: No flash read is issued during the first WAIT_CYC cycles after start. Every flash read carries command 0x03. Slot k lies at FL_BASE + k*SLOT_STRIDE. Within a slot the byte offsets are: 0 marker, 1 address/policy, 2 to 2+IMG_BYTES-1 payload, 2+IMG_BYTES CRC, 3+IMG_BYTES trailer.
- R3: A marker byte other than 0xA5 moves the sequencer to the fatal state.
- R4: Before any I2C command for a slave, arb_req is raised and the sequencer waits for arb_gnt. i2c_req is only asserted while both arb_req and arb_gnt are high. arb_req is low between slaves and in the fatal state.
- R5: In byte 1, bit 7 = 1 marks a mandatory slave and bits 6:0 give the I2C address used on every command to that slave.
- R6: An optional slave whose slv_present bit is 0 receives no I2C command and is skipped. The presence bit of a mandatory slave has no effect.
- R7: The identity query (op 0) must return ack = 1 and i2c_rdata = EXP_ID. Otherwise a mandatory slave causes the fatal state and an optional slave is skipped.
- R8: Status reads (op 1) are repeated while bit 0 (busy) of the returned byte is 1. No payload is written before a status read has returned bit 0 = 0.
- R9: Programming writes every payload byte with op 2 (i2c_idx = byte index, i2c_wdata = byte), then the CRC byte with op 3, then polls status. A returned bit 1 = 1 (CRC error) restarts the payload writes for that slave from index 0.
- R10: A slave whose CRC check fails on MAX_RETRY+1 attempts causes the fatal state.
- R11: A passing CRC check is followed by exactly one load command (op 4) and a trailer read before the next slot is started.
- R12: In the fatal state, fail and busy stay 1 and no flash, arbiter or I2C request is issued until reset. A missing ack on any command after the identity query is also fatal.
- R13: A flash or I2C request, once raised, stays high with unchanged fields until its completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start | input | 1 | Start pulse after the backup-image boot |
| fl_req | output | 1 | Flash byte read request |
| fl_cmd | output | 8 | Flash read command (0x03) |
| fl_addr | output | AW | Flash byte address |
| fl_vld | input | 1 | Flash read completion strobe |
| fl_data | input | 8 | Flash read byte, valid with fl_vld |
| arb_req | output | 1 | Shared I2C bus request |
| arb_gnt | input | 1 | Shared I2C bus grant |
| i2c_req | output | 1 | I2C command request |
| i2c_op | output | 3 | Command: 0 identity, 1 status, 2 payload write, 3 CRC write, 4 load |
| i2c_addr | output | 7 | Slave I2C address |
| i2c_idx | output | 8 | Payload byte index |
| i2c_wdata | output | 8 | Write byte |
| i2c_done | input | 1 | Command completion strobe |
| i2c_ack | input | 1 | Slave acknowledged, valid with i2c_done |
| i2c_rdata | input | 8 | Returned byte, valid with i2c_done |
| slv_present | input | N_SLV | Per-slot presence/reset line |
| busy | output | 1 | Sequence in progress or halted; slaves held safe |
| fail | output | 1 | Fatal condition latched |

## Verification
The assertions assume that the arbiter holds arb_gnt high for as long as arb_req stays high. They also assume that fl_vld and i2c_done are one-cycle strobes, given only while the matching request is pending. The stimulus meets these assumptions. It grants after a random delay and drops the grant only when the request falls. It answers each flash and I2C request exactly once, after 0 to 2 idle cycles. Slots take random policy bits, presence lines, identity answers, busy-poll counts and injected CRC failures. The bench checks the outcome against a slot-by-slot model.

// File: rtl/gcfg_pkg.sv
`timescale 1ns/1ps
package gcfg_pkg;
   typedef enum logic [4:0] {
      ST_IDLE, ST_WAIT, ST_HDR, ST_ADR, ST_ARB, ST_PROBE, ST_ID, ST_STAT,
      ST_RDD, ST_WRD, ST_RDC, ST_WRC, ST_CHK, ST_LOAD, ST_FOOT, ST_NEXT,
      ST_DONE, ST_FAIL
   } gseq_st_e;

   localparam logic [2:0] OP_RD_ID  = 3'd0;
   localparam logic [2:0] OP_RD_ST  = 3'd1;
   localparam logic [2:0] OP_WR_DAT = 3'd2;
   localparam logic [2:0] OP_WR_CRC = 3'd3;
   localparam logic [2:0] OP_LOAD   = 3'd4;

   localparam logic [7:0] HDR_MAGIC = 8'hA5;
   localparam logic [7:0] FL_RD_CMD = 8'h03;
   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned STAT_CRC_BIT  = 1;
endpackage

// File: rtl/gcfg_wait_tmr.sv
`timescale 1ns/1ps
module gcfg_wait_tmr #(
   parameter int unsigned CYC = 100000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = run && (cnt == LAST);

   // R2
   tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/gcfg_flash_rd.sv
`timescale 1ns/1ps
module gcfg_flash_rd #(
   parameter int unsigned AW = 24
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] go_addr,
   output logic          fl_req,
   output logic [AW-1:0] fl_addr,
   input  logic          fl_vld,
   output logic          done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_req  <= 1'b0;
         fl_addr <= '0;
      end else if (go) begin
         fl_req  <= 1'b1;
         fl_addr <= go_addr;
      end else if (fl_vld) begin
         fl_req  <= 1'b0;
      end
   end

   assign done = fl_req && fl_vld;

   // R13
   fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && !fl_vld |=> fl_req && $stable(fl_addr));

   // R13
   fl_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !fl_req);
endmodule

// File: rtl/gcfg_i2c_cmd.sv
`timescale 1ns/1ps
module gcfg_i2c_cmd (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [2:0] op_in,
   input  logic [6:0] addr_in,
   input  logic [7:0] idx_in,
   input  logic [7:0] wdata_in,
   output logic       i2c_req,
   output logic [2:0] i2c_op,
   output logic [6:0] i2c_addr,
   output logic [7:0] i2c_idx,
   output logic [7:0] i2c_wdata,
   input  logic       i2c_done,
   output logic       done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i2c_req   <= 1'b0;
         i2c_op    <= '0;
         i2c_addr  <= '0;
         i2c_idx   <= '0;
         i2c_wdata <= '0;
      end else if (go) begin
         i2c_req   <= 1'b1;
         i2c_op    <= op_in;
         i2c_addr  <= addr_in;
         i2c_idx   <= idx_in;
         i2c_wdata <= wdata_in;
      end else if (i2c_done) begin
         i2c_req   <= 1'b0;
      end
   end

   assign done = i2c_req && i2c_done;

   // R13
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i2c_req && !i2c_done |=> i2c_req && $stable(i2c_op) && $stable(i2c_addr)
                               && $stable(i2c_idx) && $stable(i2c_wdata));

   // R13
   cmd_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !i2c_req);
endmodule

// File: rtl/gcfg_seq_top.sv
`timescale 1ns/1ps
module gcfg_seq_top
   import gcfg_pkg::*;
#(
   parameter int unsigned N_SLV       = 4,
   parameter int unsigned IMG_BYTES   = 8,
   parameter int unsigned AW          = 24,
   parameter int unsigned FL_BASE     = 32'h0003_C000,
   parameter int unsigned SLOT_STRIDE = 256,
   parameter int unsigned WAIT_CYC    = 100000,
   parameter int unsigned MAX_RETRY   = 3,
   parameter logic [7:0]  EXP_ID      = 8'h2C
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             fl_req,
   output logic [7:0]       fl_cmd,
   output logic [AW-1:0]    fl_addr,
   input  logic             fl_vld,
   input  logic [7:0]       fl_data,
   output logic             arb_req,
   input  logic             arb_gnt,
   output logic             i2c_req,
   output logic [2:0]       i2c_op,
   output logic [6:0]       i2c_addr,
   output logic [7:0]       i2c_idx,
   output logic [7:0]       i2c_wdata,
   input  logic             i2c_done,
   input  logic             i2c_ack,
   input  logic [7:0]       i2c_rdata,
   input  logic [N_SLV-1:0] slv_present,
   output logic             busy,
   output logic             fail
);
   localparam int unsigned SLV_W    = (N_SLV > 1) ? $clog2(N_SLV) : 1;
   localparam int unsigned TRY_W    = $clog2(MAX_RETRY + 2);
   localparam logic [SLV_W-1:0] LAST_SLV = SLV_W'(N_SLV - 1);
   localparam logic [7:0]   LAST_IDX = 8'(IMG_BYTES - 1);
   localparam logic [7:0]   OFF_CRC  = 8'(IMG_BYTES + 2);
   localparam logic [7:0]   OFF_FOOT = 8'(IMG_BYTES + 3);
   localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_RETRY);

   // elaboration-time parameter checks
   generate
      if (N_SLV < 1 || N_SLV > 8) begin : g_bad_nslv
         $error("gcfg_seq_top: N_SLV must be 1..8");
      end
      if (IMG_BYTES < 1 || IMG_BYTES + 4 > SLOT_STRIDE || IMG_BYTES > 250) begin : g_bad_img
         $error("gcfg_seq_top: image does not fit its slot");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("gcfg_seq_top: WAIT_CYC must be at least 1");
      end
      if (AW < 16 || AW > 32) begin : g_bad_aw
         $error("gcfg_seq_top: AW must be 16..32");
      end
   endgenerate

   gseq_st_e         state;
   logic [SLV_W-1:0] slv;
   logic [7:0]       bidx;
   logic [TRY_W-1:0] tries;
   logic             launched;
   logic             mand;
   logic [6:0]       taddr;
   logic [7:0]       xbyte;

   logic             is_rd, is_cmd;
   logic             rd_go, cmd_go, rd_done, cmd_done, tmr_done;
   logic [7:0]       rd_off;
   logic [2:0]       cmd_op;
   logic [AW-1:0]    slot_base;
   logic [AW-1:0]    rd_addr;

   // slot base: shift when the stride is a power of two, multiply otherwise
   generate
      if ((SLOT_STRIDE & (SLOT_STRIDE - 1)) == 0) begin : g_pow2
         localparam int unsigned SH = $clog2(SLOT_STRIDE);
         assign slot_base = AW'(FL_BASE) + (AW'(slv) << SH);
      end else begin : g_mul
         assign slot_base = AW'(FL_BASE) + AW'(slv) * AW'(SLOT_STRIDE);
      end
   endgenerate

   always_comb begin
      is_rd  = 1'b0;
      is_cmd = 1'b0;
      rd_off = 8'd0;
      cmd_op = OP_RD_ST;
      case (state)
         ST_HDR:  begin is_rd = 1'b1; rd_off = 8'd0; end
         ST_ADR:  begin is_rd = 1'b1; rd_off = 8'd1; end
         ST_RDD:  begin is_rd = 1'b1; rd_off = bidx + 8'd2; end
         ST_RDC:  begin is_rd = 1'b1; rd_off = OFF_CRC; end
         ST_FOOT: begin is_rd = 1'b1; rd_off = OFF_FOOT; end
         ST_ID:   begin is_cmd = 1'b1; cmd_op = OP_RD_ID; end
         ST_STAT: begin is_cmd = 1'b1; cmd_op = OP_RD_ST; end
         ST_CHK:  begin is_cmd = 1'b1; cmd_op = OP_RD_ST; end
         ST_WRD:  begin is_cmd = 1'b1; cmd_op = OP_WR_DAT; end
         ST_WRC:  begin is_cmd = 1'b1; cmd_op = OP_WR_CRC; end
         ST_LOAD: begin is_cmd = 1'b1; cmd_op = OP_LOAD; end
         default: ;
      endcase
   end

   assign rd_go   = is_rd && !launched;
   assign cmd_go  = is_cmd && !launched;
   assign rd_addr = slot_base + AW'(rd_off);

   always_comb begin
      case (state)
         ST_ARB, ST_PROBE, ST_ID, ST_STAT, ST_RDD, ST_WRD,
         ST_RDC, ST_WRC, ST_CHK, ST_LOAD: arb_req = 1'b1;
         default:                         arb_req = 1'b0;
      endcase
   end

   assign busy   = (state != ST_IDLE) && (state != ST_DONE);
   assign fail   = (state == ST_FAIL);
   assign fl_cmd = FL_RD_CMD;

   gcfg_wait_tmr #(.CYC(WAIT_CYC)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_WAIT),
      .done (tmr_done)
   );

   gcfg_flash_rd #(.AW(AW)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (rd_go),
      .go_addr(rd_addr),
      .fl_req (fl_req),
      .fl_addr(fl_addr),
      .fl_vld (fl_vld),
      .done   (rd_done)
   );

   gcfg_i2c_cmd u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (cmd_go),
      .op_in    (cmd_op),
      .addr_in  (taddr),
      .idx_in   (bidx),
      .wdata_in (xbyte),
      .i2c_req  (i2c_req),
      .i2c_op   (i2c_op),
      .i2c_addr (i2c_addr),
      .i2c_idx  (i2c_idx),
      .i2c_wdata(i2c_wdata),
      .i2c_done (i2c_done),
      .done     (cmd_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         launched <= 1'b0;
      end else if (rd_done || cmd_done) begin
         launched <= 1'b0;
      end else if (rd_go || cmd_go) begin
         launched <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         slv   <= '0;
         bidx  <= '0;
         tries <= '0;
         mand  <= 1'b0;
         taddr <= '0;
         xbyte <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) state <= ST_WAIT;
            ST_WAIT: if (tmr_done) state <= ST_HDR;
            ST_HDR: if (rd_done) state <= (fl_data == HDR_MAGIC) ? ST_ADR : ST_FAIL;
            ST_ADR: if (rd_done) begin
               mand  <= fl_data[7];
               taddr <= fl_data[6:0];
               state <= ST_ARB;
            end
            ST_ARB: if (arb_gnt) state <= ST_PROBE;
            ST_PROBE: state <= (!mand && !slv_present[slv]) ? ST_FOOT : ST_ID;
            ST_ID: if (cmd_done) begin
               if (i2c_ack && i2c_rdata == EXP_ID) state <= ST_STAT;
               else state <= mand ? ST_FAIL : ST_FOOT;
            end
            ST_STAT: if (cmd_done) begin
               if (!i2c_ack) state <= ST_FAIL;
               else if (!i2c_rdata[STAT_BUSY_BIT]) begin
                  bidx  <= '0;
                  state <= ST_RDD;
               end
            end
            ST_RDD: if (rd_done) begin
               xbyte <= fl_data;
               state <= ST_WRD;
            end
            ST_WRD: if (cmd_done) begin
               if (!i2c_ack) state <= ST_FAIL;
               else if (bidx == LAST_IDX) state <= ST_RDC;
               else begin
                  bidx  <= bidx + 8'd1;
                  state <= ST_RDD;
               end
            end
            ST_RDC: if (rd_done) begin
               xbyte <= fl_data;
               state <= ST_WRC;
            end
            ST_WRC: if (cmd_done) state <= i2c_ack ? ST_CHK : ST_FAIL;
            ST_CHK: if (cmd_done) begin
               if (!i2c_ack) state <= ST_FAIL;
               else if (i2c_rdata[STAT_BUSY_BIT]) state <= ST_CHK;
               else if (i2c_rdata[STAT_CRC_BIT]) begin
                  if (tries == TRY_MAX) state <= ST_FAIL;
                  else begin
                     tries <= tries + 1'b1;
                     bidx  <= '0;
                     state <= ST_RDD;
                  end
               end else state <= ST_LOAD;
            end
            ST_LOAD: if (cmd_done) state <= i2c_ack ? ST_FOOT : ST_FAIL;
            ST_FOOT: if (rd_done) state <= ST_NEXT;
            ST_NEXT: begin
               tries <= '0;
               if (slv == LAST_SLV) state <= ST_DONE;
               else begin
                  slv   <= slv + 1'b1;
                  state <= ST_HDR;
               end
            end
            ST_DONE: state <= ST_DONE;
            default: state <= ST_FAIL;
         endcase
      end
   end

   // R12
   fail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> busy);

   // R12
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> fail);

   // R12
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !fl_req && !i2c_req && !arb_req);

   // R4
   i2c_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i2c_req |-> arb_req && arb_gnt);

   // R2
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT |-> !fl_req);

   // R10
   retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= TRY_MAX);

   // R1
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !fail && !arb_req);
endmodule

// File: tb/gcfg_seq_tb_top.sv
`timescale 1ns/1ps
module gcfg_seq_tb_top;
   localparam int NS    = 4;
   localparam int IMG   = 6;
   localparam int WAITC = 40;
   localparam int MR    = 2;
   localparam logic [7:0]  XID  = 8'h2C;
   localparam logic [23:0] BASE = 24'h03C000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic fl_req, fl_vld;
   logic [7:0] fl_cmd, fl_data;
   logic [23:0] fl_addr;
   logic arb_req, arb_gnt;
   logic i2c_req, i2c_done, i2c_ack;
   logic [2:0] i2c_op;
   logic [6:0] i2c_addr;
   logic [7:0] i2c_idx, i2c_wdata, i2c_rdata;
   logic [NS-1:0] slv_present;
   logic busy, fail;

   gcfg_seq_top #(
      .N_SLV(NS), .IMG_BYTES(IMG), .AW(24), .FL_BASE(32'h0003_C000),
      .SLOT_STRIDE(256), .WAIT_CYC(WAITC), .MAX_RETRY(MR), .EXP_ID(XID)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fl_req(fl_req), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_vld(fl_vld), .fl_data(fl_data),
      .arb_req(arb_req), .arb_gnt(arb_gnt),
      .i2c_req(i2c_req), .i2c_op(i2c_op), .i2c_addr(i2c_addr), .i2c_idx(i2c_idx),
      .i2c_wdata(i2c_wdata), .i2c_done(i2c_done), .i2c_ack(i2c_ack), .i2c_rdata(i2c_rdata),
      .slv_present(slv_present), .busy(busy), .fail(fail)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit all_done = 1'b0;

   // scenario configuration
   bit   hdr_ok[NS], mand[NS], ack_ok[NS], id_ok[NS];
   int   crc_bad[NS], bpolls[NS];
   logic [7:0] img[NS][IMG];
   // slave model state
   logic [7:0] rx[NS][IMG];
   int   att[NS], loads[NS], cmds[NS], sleft[NS];
   bit   sok[NS], cerr[NS];
   int   cyc_cnt, gap;
   bit   seen_rd;
   // expectations
   bit   exp_fail;
   int   exp_load[NS], exp_att[NS], exp_cmds0[NS];

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] crc8(logic [7:0] b[IMG]);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < IMG; i++) begin
         c = c ^ b[i];
         for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [7:0] fbyte(int s, int o);
      if (o == 0) return hdr_ok[s] ? 8'hA5 : 8'h3C;
      if (o == 1) return {mand[s], 7'(7'h40 + s)};
      if (o < 2 + IMG) return img[s][o-2];
      if (o == 2 + IMG) return crc8(img[s]);
      return 8'h5A;
   endfunction

   // expected outcome, slot by slot (R3 R6 R7 R10 R11)
   task automatic compute_exp();
      exp_fail = 1'b0;
      for (int k = 0; k < NS; k++) begin
         exp_load[k] = 0; exp_att[k] = 0; exp_cmds0[k] = 1;
      end
      for (int k = 0; k < NS; k++) begin
         if (!hdr_ok[k]) begin exp_fail = 1'b1; break; end
         if (!mand[k] && !slv_present[k]) continue;
         exp_cmds0[k] = 0;
         if (!ack_ok[k] || !id_ok[k]) begin
            if (mand[k]) begin exp_fail = 1'b1; break; end
            continue;
         end
         if (crc_bad[k] > MR) begin exp_att[k] = MR + 1; exp_fail = 1'b1; break; end
         exp_att[k] = crc_bad[k] + 1;
         exp_load[k] = 1;
      end
   endtask

   task automatic slave_op(int s, logic [2:0] op, logic [7:0] idx, logic [7:0] wd,
                           output logic ack, output logic [7:0] rd);
      ack = 1'b1; rd = 8'h00;
      cmds[s]++;
      case (op)
         3'd0: begin
            ack = ack_ok[s]; rd = id_ok[s] ? XID : 8'h71;
            sok[s] = 1'b0; sleft[s] = bpolls[s];
         end
         3'd1: begin
            if (sleft[s] > 0) begin rd = 8'h01; sleft[s]--; end
            else begin rd = {6'b0, cerr[s], 1'b0}; sok[s] = 1'b1; end
         end
         3'd2: begin
            if (!sok[s]) chk(0, "R8", "payload write before ready status", 0, 1);
            if (idx < IMG) rx[s][idx] = wd;
            else chk(0, "R9", "payload index out of range", idx, IMG - 1);
         end
         3'd3: begin
            att[s]++;
            cerr[s] = (wd != crc8(rx[s])) || (att[s] <= crc_bad[s]);
            sleft[s] = bpolls[s];
         end
         3'd4: begin
            loads[s]++;
            for (int i = 0; i < IMG; i++)
               chk(rx[s][i] == img[s][i], "R9", "shadow byte after load", rx[s][i], img[s][i]);
         end
         default: chk(0, "R9", "unknown opcode", op, 0);
      endcase
   endtask

   // flash responder
   initial begin
      fl_vld = 1'b0; fl_data = 8'h00;
      forever begin
         @(negedge clk);
         if (fl_req) begin
            automatic logic [23:0] a = fl_addr;
            automatic int d = $urandom % 3;
            automatic int s, o;
            if (!seen_rd) begin seen_rd = 1'b1; gap = cyc_cnt; end
            if (fl_cmd != 8'h03) chk(0, "R2", "flash command", fl_cmd, 8'h03);
            s = int'(a - BASE) >> 8;
            o = int'(a[7:0]);
            if (a < BASE || s >= NS || o > IMG + 3) begin
               chk(0, "R2", "flash address outside image slots", a, BASE);
               s = 0;
            end
            repeat (d) begin
               @(negedge clk);
               if (!fl_req || fl_addr != a) chk(0, "R13", "flash request changed while pending", fl_addr, a);
            end
            fl_data = fbyte(s, o);
            fl_vld = 1'b1;
            @(negedge clk);
            fl_vld = 1'b0;
         end
      end
   end

   // I2C responder
   initial begin
      i2c_done = 1'b0; i2c_ack = 1'b0; i2c_rdata = 8'h00;
      forever begin
         @(negedge clk);
         if (i2c_req) begin
            automatic logic [2:0] op = i2c_op;
            automatic logic [7:0] wd = i2c_wdata;
            automatic logic [7:0] ix = i2c_idx;
            automatic int s = int'(i2c_addr) - 'h40;
            automatic int d = $urandom % 3;
            automatic logic a;
            automatic logic [7:0] r;
            if (!arb_gnt) chk(0, "R4", "I2C command without grant", 0, 1);
            if (s < 0 || s >= NS) begin
               chk(0, "R5", "I2C address unknown", i2c_addr, 7'h40);
               s = 0;
            end
            repeat (d) begin
               @(negedge clk);
               if (!i2c_req || i2c_op != op || i2c_wdata != wd)
                  chk(0, "R13", "I2C request changed while pending", i2c_op, op);
            end
            slave_op(s, op, ix, wd, a, r);
            i2c_ack = a; i2c_rdata = r; i2c_done = 1'b1;
            @(negedge clk);
            i2c_done = 1'b0;
         end
      end
   end

   // arbiter
   initial begin
      arb_gnt = 1'b0;
      forever begin
         @(negedge clk);
         if (!arb_req) arb_gnt = 1'b0;
         else if (!arb_gnt && ($urandom % 3 == 0)) arb_gnt = 1'b1;
      end
   end

   initial begin
      cyc_cnt = 0;
      forever begin @(negedge clk); cyc_cnt++; end
   end

   task automatic cfg_default();
      for (int k = 0; k < NS; k++) begin
         hdr_ok[k] = 1; mand[k] = 1; ack_ok[k] = 1; id_ok[k] = 1;
         crc_bad[k] = 0; bpolls[k] = 0; slv_present[k] = 1'b1;
         for (int i = 0; i < IMG; i++) img[k][i] = 8'($urandom);
      end
   endtask

   task automatic cfg_random();
      cfg_default();
      for (int k = 0; k < NS; k++) begin
         hdr_ok[k] = ($urandom % 16) != 0;
         mand[k] = $urandom % 2;
         slv_present[k] = ($urandom % 4) != 0;
         ack_ok[k] = ($urandom % 8) != 0;
         id_ok[k] = ($urandom % 8) != 0;
         crc_bad[k] = $urandom % 4;
         bpolls[k] = $urandom % 3;
      end
   endtask

   task automatic run_case(string tag);
      int tot;
      compute_exp();
      for (int k = 0; k < NS; k++) begin
         att[k] = 0; loads[k] = 0; cmds[k] = 0; sleft[k] = 0; sok[k] = 0; cerr[k] = 0;
         for (int i = 0; i < IMG; i++) rx[k][i] = 8'h00;
      end
      seen_rd = 1'b0; gap = 0;
      rst_n = 1'b0; start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !fail && !fl_req && !i2c_req && !arb_req, "R1", {tag, " reset state"},
          {busy, fail, fl_req, i2c_req, arb_req}, 0);
      start = 1'b1;
      cyc_cnt = 0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1", {tag, " busy after start"}, busy, 1);
      begin : wait_end
         for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (fail || !busy) disable wait_end;
         end
         chk(0, tag, "run did not finish", busy, 0);
      end
      chk(!seen_rd || gap >= WAITC, "R2", {tag, " startup wait before first flash read"}, gap, WAITC);
      if (fail) begin
         tot = 0;
         for (int k = 0; k < NS; k++) tot += cmds[k];
         start = 1'b1;
         repeat (30) @(negedge clk);
         start = 1'b0;
         for (int k = 0; k < NS; k++) tot -= cmds[k];
         chk(tot == 0 && fail && busy && !arb_req && !fl_req, "R12",
             {tag, " halted state stays quiet"}, tot, 0);
      end
      chk(fail == exp_fail, tag, "fail flag", fail, exp_fail);
      chk(busy == exp_fail, "R1", {tag, " busy at end"}, busy, exp_fail);
      chk(arb_req == 1'b0, "R4", {tag, " bus released"}, arb_req, 0);
      for (int k = 0; k < NS; k++) begin
         chk(loads[k] == exp_load[k], "R11", {tag, " load count"}, loads[k], exp_load[k]);
         chk(att[k] == exp_att[k], "R9", {tag, " programming attempts"}, att[k], exp_att[k]);
         if (exp_cmds0[k]) chk(cmds[k] == 0, "R6", {tag, " skipped slot untouched"}, cmds[k], 0);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      slv_present = '1;
      // R1 R11 all slots mandatory and healthy
      cfg_default();
      run_case("R11");
      // R3 bad marker in slot 2
      cfg_default(); hdr_ok[2] = 0;
      run_case("R3");
      // R6 optional absent slot is skipped
      cfg_default(); mand[1] = 0; slv_present[1] = 1'b0; mand[3] = 0;
      run_case("R6");
      // R6 presence line ignored for a mandatory slot
      cfg_default(); slv_present[0] = 1'b0; slv_present[2] = 1'b0;
      run_case("R6");
      // R7 optional present slot with wrong identity is skipped
      cfg_default(); mand[0] = 0; id_ok[0] = 0;
      run_case("R7");
      // R7 mandatory slot without ack stops the run
      cfg_default(); ack_ok[1] = 0;
      run_case("R7");
      // R8 status busy polls
      cfg_default();
      for (int k = 0; k < NS; k++) bpolls[k] = 3;
      run_case("R8");
      // R9 CRC retries that recover
      cfg_default(); crc_bad[0] = 1; crc_bad[3] = MR;
      run_case("R9");
      // R10 persistent CRC failure
      cfg_default(); crc_bad[2] = MR + 1;
      run_case("R10");
      // R5 random mixes
      for (int n = 0; n < 8; n++) begin
         cfg_random();
         run_case("R5");
      end
      all_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!all_done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule